// File: doc/BRIEF.md
# Crate Bus Command Decoder with Interrupt Logic

This block sits between a crate backplane and a module that holds eight
measurement words, each made of an 11-bit value and an overflow flag. It
decodes the station select, the subaddress and the 5-bit function code of each
bus command. It answers with the accepted (X) and response (Q) lines. For read
functions it puts the addressed word on a 12-bit read bus. The word comes from
an external register file, and the block drives that file's read address from
the subaddress.

The block also keeps a service request (LAM) and the mask that gates it. The
request is raised when the converter reports the end of a conversion. Side
effects happen only in a cycle where the strobe (S2) is high, and the strobe is
taken as a one-cycle pulse. Those side effects are: module clear, request
clear, mask enable or disable, and self-test launch. Module clear and self-test
leave the block as registered one-cycle pulses. An optional suppression mode
makes a module with no stored hit look like an empty slot, which removes both Q
and the service request.

Top module: `cbus_cmd_dec`

## Requirements
- R1: `x_resp` is 1 exactly when `stn_sel` is 1 and `func` is one of 0, 2, 8, 9, 10, 24, 25, 26. The subaddress value has no effect on it.
- R2: When `stn_sel` is 1 and `func` is 0 or 2, `rd_data` equals `chan_data` (bits 10..0 are the value, bit 11 is the overflow flag) and `chan_addr` equals `sub_addr`. In every other case `rd_data` is 0.
- R3: `q_resp` is 1 for a selected F0 or F2, and for a selected F8 only while the request is pending and the mask is enabled. In all other cases it is 0. Suppression (R10) overrides this.
- R4: A `conv_end` pulse sets the request from the next cycle on. The request then holds until a request clear or a module clear.
- R5: `lam_out` is the pending request gated by the mask. It is forced to 0 while `stn_sel` is 1.
- R6: A strobed F10 clears the request without a module clear pulse. If `conv_end` falls in the same cycle, the request stays set.
- R7: A module clear comes from a strobed F9, a strobed F2 with subaddress 7, or a strobed `bus_clear` or `bus_init` (these two need no `stn_sel`). It gives a one-cycle `mod_clear` pulse in the next cycle and clears the request, even against a coincident `conv_end`. A strobed F2 with any other subaddress clears nothing.
- R8: The mask is 0 after reset. A strobed F26 sets it. A strobed F24 or a strobed `bus_init` clears it, and `bus_init` wins over F26. `bus_clear` and F9 leave it unchanged.
- R9: A strobed, selected F25 gives a one-cycle `self_test` pulse in the next cycle.
- R10: When `suppress_en` is 1 and `has_data` is 0, `q_resp` and `lam_out` are both 0, while `x_resp` still follows R1.
- R11: Commands presented without the strobe change neither the request nor the mask, and produce no `mod_clear` or `self_test` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stn_sel | input | 1 | Station select (N) |
| sub_addr | input | 3 | Subaddress (A) |
| func | input | 5 | Function code (F) |
| strobe | input | 1 | S2 strobe, one-cycle pulse |
| bus_clear | input | 1 | Crate clear (C) |
| bus_init | input | 1 | Crate initialize (Z) |
| conv_end | input | 1 | End-of-conversion pulse |
| has_data | input | 1 | At least one channel holds a hit |
| suppress_en | input | 1 | Enables empty-module suppression |
| chan_data | input | 12 | Word from the register file |
| chan_addr | output | 3 | Read address to the register file |
| rd_data | output | 12 | Read bus |
| q_resp | output | 1 | Q response |
| x_resp | output | 1 | X response |
| lam_out | output | 1 | Service request |
| mod_clear | output | 1 | Module clear pulse |
| self_test | output | 1 | Self-test launch pulse |

## Verification
A request clear or a module clear can land in the same cycle as an end-of-conversion pulse. The bench provokes both cases by asserting `conv_end` in the strobe cycle of F10, F9, and the bus clear. It then reads `lam_out` one cycle later with the station deselected. An F10 must leave the request standing, and a module clear must drop it. A second collision, initialize together with mask enable, is judged the same way through a later conversion.

// File: rtl/cbus_pkg.sv
package cbus_pkg;
  localparam int FUNC_W = 5;

  localparam logic [FUNC_W-1:0] FC_READ      = 5'd0;
  localparam logic [FUNC_W-1:0] FC_READ_CLR  = 5'd2;
  localparam logic [FUNC_W-1:0] FC_TEST_REQ  = 5'd8;
  localparam logic [FUNC_W-1:0] FC_CLR_MOD   = 5'd9;
  localparam logic [FUNC_W-1:0] FC_CLR_REQ   = 5'd10;
  localparam logic [FUNC_W-1:0] FC_MASK_OFF  = 5'd24;
  localparam logic [FUNC_W-1:0] FC_SELF_TEST = 5'd25;
  localparam logic [FUNC_W-1:0] FC_MASK_ON   = 5'd26;

  typedef struct packed {
    logic rd;
    logic rd_clr_top;
    logic tst_req;
    logic clr_mod;
    logic clr_req;
    logic mask_off;
    logic self_tst;
    logic mask_on;
  } cmd_t;

  function automatic logic fc_known(input logic [FUNC_W-1:0] f);
    return (f == FC_READ) || (f == FC_READ_CLR) || (f == FC_TEST_REQ) ||
           (f == FC_CLR_MOD) || (f == FC_CLR_REQ) || (f == FC_MASK_OFF) ||
           (f == FC_SELF_TEST) || (f == FC_MASK_ON);
  endfunction

  function automatic logic is_empty(input logic supp, input logic data);
    return supp && !data;
  endfunction
endpackage

// File: rtl/cbus_decode.sv
module cbus_decode
  import cbus_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              stn_sel,
  input  logic [ADDR_W-1:0] sub_addr,
  input  logic [FUNC_W-1:0] func,
  output cmd_t              cmd,
  output logic              valid
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

  always_comb begin
    cmd            = '0;
    valid          = stn_sel && fc_known(func);
    cmd.rd         = stn_sel && ((func == FC_READ) || (func == FC_READ_CLR));
    cmd.rd_clr_top = stn_sel && (func == FC_READ_CLR) && (sub_addr == TOP_ADDR);
    cmd.tst_req    = stn_sel && (func == FC_TEST_REQ);
    cmd.clr_mod    = stn_sel && (func == FC_CLR_MOD);
    cmd.clr_req    = stn_sel && (func == FC_CLR_REQ);
    cmd.mask_off   = stn_sel && (func == FC_MASK_OFF);
    cmd.self_tst   = stn_sel && (func == FC_SELF_TEST);
    cmd.mask_on    = stn_sel && (func == FC_MASK_ON);
  end
endmodule

// File: rtl/cbus_lam.sv
module cbus_lam (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic bus_clear,
  input  logic bus_init,
  input  logic clr_mod,
  input  logic rd_clr_top,
  input  logic clr_req,
  input  logic mask_off,
  input  logic mask_on,
  input  logic self_tst,
  input  logic conv_end,
  output logic lam_req,
  output logic lam_mask,
  output logic mod_clear,
  output logic self_test
);
  logic mod_clr_ev;
  logic req_clr_ev;
  logic init_ev;

  assign init_ev    = strobe && bus_init;
  assign mod_clr_ev = strobe && (bus_clear || bus_init || clr_mod || rd_clr_top);
  assign req_clr_ev = strobe && clr_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lam_req   <= 1'b0;
      lam_mask  <= 1'b0;
      mod_clear <= 1'b0;
      self_test <= 1'b0;
    end else begin
      mod_clear <= mod_clr_ev;
      self_test <= strobe && self_tst;
      if (mod_clr_ev)      lam_req <= 1'b0;
      else if (conv_end)   lam_req <= 1'b1;
      else if (req_clr_ev) lam_req <= 1'b0;
      if (init_ev)                 lam_mask <= 1'b0;
      else if (strobe && mask_off) lam_mask <= 1'b0;
      else if (strobe && mask_on)  lam_mask <= 1'b1;
    end
  end

  p_req_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_end && !mod_clr_ev |=> lam_req);
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lam_req && !mod_clr_ev && !req_clr_ev |=> lam_req);
  p_req_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_clr_ev && !conv_end && !mod_clr_ev |=> !lam_req && !mod_clear);
  p_mod_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mod_clr_ev |=> !lam_req && mod_clear);
  p_init_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_ev |=> !lam_mask);
  p_mask_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && mask_on && !bus_init |=> lam_mask);
  p_test_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && self_tst |=> self_test);
  p_no_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> !mod_clear && !self_test && $stable(lam_mask));
endmodule

// File: rtl/cbus_resp.sv
module cbus_resp
  import cbus_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  cmd_t              cmd,
  input  logic              valid,
  input  logic              stn_sel,
  input  logic              lam_req,
  input  logic              lam_mask,
  input  logic              has_data,
  input  logic              suppress_en,
  input  logic [WORD_W-1:0] chan_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              q_resp,
  output logic              x_resp,
  output logic              lam_out
);
  logic hidden;
  logic req_live;

  assign hidden   = is_empty(suppress_en, has_data);
  assign req_live = lam_req && lam_mask && !hidden;

  always_comb begin
    x_resp  = valid;
    rd_data = cmd.rd ? chan_data : '0;
    q_resp  = !hidden && (cmd.rd || (cmd.tst_req && req_live));
    lam_out = req_live && !stn_sel;
  end

  // The unused command bits are consumed here so every struct field is read.
  logic unused_bits;
  assign unused_bits = ^{cmd.rd_clr_top, cmd.clr_mod, cmd.clr_req,
                         cmd.mask_off, cmd.self_tst, cmd.mask_on};
endmodule

// File: rtl/cbus_cmd_dec.sv
module cbus_cmd_dec
  import cbus_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int VAL_W  = 11,
  localparam int WORD_W = VAL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stn_sel,
  input  logic [ADDR_W-1:0] sub_addr,
  input  logic [FUNC_W-1:0] func,
  input  logic              strobe,
  input  logic              bus_clear,
  input  logic              bus_init,
  input  logic              conv_end,
  input  logic              has_data,
  input  logic              suppress_en,
  input  logic [WORD_W-1:0] chan_data,
  output logic [ADDR_W-1:0] chan_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              q_resp,
  output logic              x_resp,
  output logic              lam_out,
  output logic              mod_clear,
  output logic              self_test
);
  cmd_t cmd;
  logic valid;
  logic lam_req;
  logic lam_mask;

  assign chan_addr = sub_addr;

  cbus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .stn_sel(stn_sel), .sub_addr(sub_addr), .func(func),
    .cmd(cmd), .valid(valid)
  );

  cbus_lam u_lam (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .bus_clear(bus_clear), .bus_init(bus_init),
    .clr_mod(cmd.clr_mod), .rd_clr_top(cmd.rd_clr_top),
    .clr_req(cmd.clr_req), .mask_off(cmd.mask_off), .mask_on(cmd.mask_on),
    .self_tst(cmd.self_tst), .conv_end(conv_end),
    .lam_req(lam_req), .lam_mask(lam_mask),
    .mod_clear(mod_clear), .self_test(self_test)
  );

  cbus_resp #(.WORD_W(WORD_W)) u_resp (
    .cmd(cmd), .valid(valid), .stn_sel(stn_sel),
    .lam_req(lam_req), .lam_mask(lam_mask),
    .has_data(has_data), .suppress_en(suppress_en), .chan_data(chan_data),
    .rd_data(rd_data), .q_resp(q_resp), .x_resp(x_resp), .lam_out(lam_out)
  );

  p_x_needs_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    x_resp |-> stn_sel);
  p_rd_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !stn_sel |-> rd_data == '0);
  p_q_needs_x_r3: assert property (@(posedge clk) disable iff (!rst_n)
    q_resp |-> x_resp);
  p_lam_quiet_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stn_sel |-> !lam_out);
  p_empty_hides_r10: assert property (@(posedge clk) disable iff (!rst_n)
    suppress_en && !has_data |-> !q_resp && !lam_out);
endmodule

// File: tb/cbus_cmd_dec_bench.sv
module cbus_cmd_dec_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stn_sel = 1'b0, strobe = 1'b0, bus_clear = 1'b0, bus_init = 1'b0;
  logic [2:0]  sub_addr = '0;
  logic [4:0]  func = '0;
  logic        conv_end = 1'b0, has_data = 1'b1, suppress_en = 1'b0;
  logic [11:0] chan_data;
  logic [2:0]  chan_addr;
  logic [11:0] rd_data;
  logic        q_resp, x_resp, lam_out, mod_clear, self_test;
  int          total = 0;
  int          bad = 0;

  always #10 clk = ~clk;

  function automatic logic [11:0] word_of(input int a);
    return {a[0], 11'((a * 149 + 3) % 2048)};
  endfunction

  assign chan_data = word_of(int'(chan_addr));

  cbus_cmd_dec u_cbus_cmd_dec (
    .clk(clk), .rst_n(rst_n), .stn_sel(stn_sel), .sub_addr(sub_addr),
    .func(func), .strobe(strobe), .bus_clear(bus_clear), .bus_init(bus_init),
    .conv_end(conv_end), .has_data(has_data), .suppress_en(suppress_en),
    .chan_data(chan_data), .chan_addr(chan_addr), .rd_data(rd_data),
    .q_resp(q_resp), .x_resp(x_resp), .lam_out(lam_out),
    .mod_clear(mod_clear), .self_test(self_test)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    stn_sel = 0; strobe = 0; bus_clear = 0; bus_init = 0;
    func = 0; sub_addr = 0; conv_end = 0;
  endtask

  // One command cycle: inputs set at a falling edge, held over one rising edge.
  task automatic cmd(input bit n, input int f, input int a, input bit s,
                     input bit c, input bit z, input bit done);
    @(negedge clk);
    stn_sel = n; func = 5'(f); sub_addr = 3'(a); strobe = s;
    bus_clear = c; bus_init = z; conv_end = done;
    @(negedge clk);
    idle();
    #2;
  endtask

  function automatic bit known(input int f);
    return f == 0 || f == 2 || f == 8 || f == 9 || f == 10 ||
           f == 24 || f == 25 || f == 26;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    #2;
    chk("R2 reset rd_data", int'(rd_data), 0);
    chk("R1 reset x", int'(x_resp), 0);
    chk("R5 reset lam", int'(lam_out), 0);
    chk("R7 reset mod_clear", int'(mod_clear), 0);
    rst_n = 1;

    // R8: mask is off after reset, so a conversion gives no request
    cmd(0, 0, 0, 0, 0, 0, 1);
    chk("R8 mask off after reset", int'(lam_out), 0);
    // R11: F26 without strobe leaves the mask off
    cmd(1, 26, 0, 0, 0, 0, 0);
    chk("R11 F26 no strobe", int'(lam_out), 0);
    cmd(1, 25, 0, 0, 0, 0, 0);
    chk("R11 F25 no strobe", int'(self_test), 0);
    cmd(1, 9, 0, 0, 0, 0, 0);
    chk("R11 F9 no strobe", int'(mod_clear), 0);
    cmd(1, 26, 5, 1, 0, 0, 0);
    chk("R8 F26 enables", int'(lam_out), 1);
    chk("R4 request held", int'(lam_out), 1);
    @(negedge clk); stn_sel = 1; #2;
    chk("R5 masked while selected", int'(lam_out), 0);
    stn_sel = 0; #2;
    chk("R5 back when deselected", int'(lam_out), 1);

    // R6
    cmd(1, 10, 2, 1, 0, 0, 0);
    chk("R6 F10 clears", int'(lam_out), 0);
    chk("R6 F10 no module clear", int'(mod_clear), 0);
    cmd(0, 0, 0, 0, 0, 0, 1);
    chk("R4 set by conv_end", int'(lam_out), 1);
    cmd(1, 10, 0, 1, 0, 0, 0);
    cmd(1, 10, 0, 1, 0, 0, 1);
    chk("R6 conv_end beats F10", int'(lam_out), 1);

    // R7
    cmd(1, 9, 4, 1, 0, 0, 1);
    chk("R7 F9 beats conv_end", int'(lam_out), 0);
    chk("R7 F9 pulse", int'(mod_clear), 1);
    @(negedge clk); #2;
    chk("R7 pulse one cycle", int'(mod_clear), 0);
    cmd(0, 0, 0, 0, 0, 0, 1);
    cmd(1, 2, 3, 1, 0, 0, 0);
    chk("R7 F2 A3 no clear", int'(mod_clear), 0);
    chk("R7 F2 A3 keeps request", int'(lam_out), 1);
    cmd(1, 2, 7, 1, 0, 0, 0);
    chk("R7 F2 A7 clears", int'(mod_clear), 1);
    chk("R7 F2 A7 drops request", int'(lam_out), 0);
    cmd(0, 0, 0, 0, 0, 0, 1);
    cmd(0, 0, 0, 1, 1, 0, 1);
    chk("R7 C clears", int'(mod_clear), 1);
    chk("R7 C beats conv_end", int'(lam_out), 0);
    cmd(0, 0, 0, 0, 0, 0, 1);
    chk("R8 C keeps mask", int'(lam_out), 1);
    cmd(1, 9, 0, 1, 0, 0, 0);
    cmd(0, 0, 0, 0, 0, 0, 1);
    chk("R8 F9 keeps mask", int'(lam_out), 1);
    cmd(1, 26, 0, 1, 0, 1, 0);
    chk("R7 Z clears", int'(mod_clear), 1);
    cmd(0, 0, 0, 0, 0, 0, 1);
    chk("R8 Z beats F26", int'(lam_out), 0);
    cmd(1, 26, 0, 1, 0, 0, 0);
    chk("R8 re-enabled", int'(lam_out), 1);
    cmd(1, 24, 6, 1, 0, 0, 0);
    chk("R8 F24 disables", int'(lam_out), 0);
    cmd(1, 26, 1, 1, 0, 0, 0);

    // R9
    cmd(1, 25, 6, 1, 0, 0, 0);
    chk("R9 self test pulse", int'(self_test), 1);
    @(negedge clk); #2;
    chk("R9 pulse one cycle", int'(self_test), 0);

    // R10
    @(negedge clk); suppress_en = 1; has_data = 0; #2;
    chk("R10 lam hidden", int'(lam_out), 0);
    stn_sel = 1; func = 0; sub_addr = 4; #2;
    chk("R10 q hidden F0", int'(q_resp), 0);
    chk("R10 x kept", int'(x_resp), 1);
    func = 8; #2;
    chk("R10 q hidden F8", int'(q_resp), 0);
    stn_sel = 0; has_data = 1; #2;
    chk("R10 lam with data", int'(lam_out), 1);
    suppress_en = 0;

    // R1 R2 R3 sweep with request pending and mask enabled
    for (int n = 0; n < 2; n++)
      for (int f = 0; f < 32; f++)
        for (int a = 0; a < 8; a++) begin
          @(negedge clk);
          stn_sel = n[0]; func = 5'(f); sub_addr = 3'(a);
          #2;
          chk("R1 x sweep", int'(x_resp), int'(n == 1 && known(f)));
          chk("R2 data sweep", int'(rd_data),
              (n == 1 && (f == 0 || f == 2)) ? int'(word_of(a)) : 0);
          chk("R3 q sweep", int'(q_resp),
              int'(n == 1 && (f == 0 || f == 2 || f == 8)));
        end
    idle();
    #2;
    chk("R11 sweep left request", int'(lam_out), 1);
    cmd(1, 10, 0, 1, 0, 0, 0);
    @(negedge clk); stn_sel = 1; func = 8; #2;
    chk("R3 F8 without request", int'(q_resp), 0);
    idle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule